// File: doc/BRIEF.md
# Synchronised DAC Data Front End

This block is the digital path that sits in front of a 12-bit digital-to-analog converter. It chooses which code the converter sees and when that code changes. There are three possible sources. The first is a buffered register written over a 16-bit bus. The second is a 16-entry FIFO that a DMA engine fills. The third is an internal generator that produces sawtooth, triangle or square waves between programmable lower and upper bounds.

Bus and DMA words arrive as 16-bit words. They pass through one of two justification formats and come out as 12-bit codes. In asynchronous operation a code moves to the output as soon as it is available. In synchronous operation the output moves only on an external sync pulse, which gives a tightly timed ramp or step sequence.

Both data inputs use valid/ready handshakes. A word is taken only in a cycle where valid and ready are both high. The bus input drops ready for as long as DMA is enabled. The DMA input drops ready whenever DMA is disabled or the FIFO holds 16 words. A word offered while ready is low is not taken, and the sender must keep it until ready returns. All configuration, sync and power-down pins are plain levels sampled on each rising clock edge.

Top module: `dacfe_top`

## Requirements
- R1: `fmt_sel`=0 takes the code from word bits 11:0. `fmt_sel`=1 takes it from word bits 15:4. The same rule applies to bus words and to DMA words.
- R2: With `sync_en`=0, `dma_en`=0 and `auto_en`=0, an accepted bus write appears on `dac_code` after the clock edge that accepts it.
- R3: With `sync_en`=1, `dac_code` changes only on an edge where `sync_in`=1. A buffered bus value reaches the output at the first such pulse after it is written.
- R4: Wave code 0 is the sawtooth. Each update emits the current value and then advances by `step_val`, clamped at `max_val`. After `max_val` the next value is `min_val`. The sequence starts at `min_val` when `auto_en` rises.
- R5: Wave code 1 is the triangle. It rises by `step_val` up to `max_val` (clamped), then falls by `step_val` down to `min_val` (clamped). Each bound is emitted once at every turn.
- R6: Wave code 2 is the square. It alternates between `min_val` and `max_val`, starting at `min_val`.
- R7: The DMA FIFO holds 16 words and returns them in arrival order. `dma_ready` is low when the FIFO is full. `wr_ready` is low while `dma_en`=1. A word offered while the FIFO is full is not stored.
- R8: `dma_req` is high one cycle after a cycle in which DMA is enabled, the fill level is at or below `watermark`, and `dma_ack` is low. In the cycle after `dma_ack`, `dma_req` is low.
- R9: In synchronous DMA operation, a sync pulse that finds the FIFO empty leaves `dac_code` unchanged and sets `underflow`. Only reset clears `underflow`.
- R10: While `pdn`=1, `dac_code` reads 0 and update events are ignored. When `pdn` falls, the code that was held before power-down returns.
- R11: With `watermark`=6 and a 24-word DMA ramp from 0x000 to 0xFFF, the output equals ramp entry k after sync event k+1. It reads 0xFFF after the 24th sync event.
- R12: After reset, `dac_code`=0, `dma_req`=0 and `underflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 1 | Word justification: 0 right, 1 left |
| sync_en | input | 1 | 1 = updates wait for sync_in |
| dma_en | input | 1 | 1 = codes come from the DMA FIFO; 0 also empties the FIFO |
| auto_en | input | 1 | 1 = codes come from the wave generator |
| pdn | input | 1 | Power-down: output forced to 0, updates frozen |
| wave_sel | input | 2 | 0 sawtooth, 1 triangle, 2 square, 3 hold |
| min_val | input | 12 | Generator lower bound |
| max_val | input | 12 | Generator upper bound |
| step_val | input | 12 | Generator increment |
| watermark | input | 5 | FIFO level at or below which DMA is requested |
| wr_valid | input | 1 | Bus word valid |
| wr_ready | output | 1 | Bus word ready |
| wr_data | input | 16 | Bus word |
| dma_valid | input | 1 | DMA word valid |
| dma_ready | output | 1 | DMA word ready (FIFO not full) |
| dma_data | input | 16 | DMA word |
| dma_req | output | 1 | DMA service request |
| dma_ack | input | 1 | DMA acknowledge |
| sync_in | input | 1 | Update pulse |
| dac_code | output | 12 | Code presented to the converter |
| underflow | output | 1 | Sticky FIFO underflow flag |

## Verification
Every source ends in the single output register. A wrong pointer, wrong level or wrong generator direction therefore shows up as a wrong `dac_code` on the very next update event. The sweeps issue one event per check, so a fault shows within one sync pulse of its cause. A miscounted FIFO level shows at `dma_req` or `dma_ready` within two cycles of the push or pop that caused it. A lost or duplicated FIFO entry shifts every later value in the ordered readback. A misplaced turn in the generator breaks every later value in the modelled wave sequence, so a fault persists rather than appearing once.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [1:0] {
    WAVE_SAW = 2'd0,
    WAVE_TRI = 2'd1,
    WAVE_SQR = 2'd2,
    WAVE_HLD = 2'd3
  } wave_e;
endpackage

// File: rtl/dacfe_fmt.sv
module dacfe_fmt #(
  parameter int BW = 16,
  parameter int DW = 12
) (
  input  logic          sel,
  input  logic [BW-1:0] word,
  output logic [DW-1:0] code
);
  // sel=0: low justified, sel=1: high justified
  always_comb begin
    if (sel) code = word[BW-1:BW-DW];
    else     code = word[DW-1:0];
  end
endmodule

// File: rtl/dacfe_fifo.sv
module dacfe_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL) else $error("fifo level above depth");

  assert_level_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !clr) |=> (level == $past(level) + 1'b1))
    else $error("fifo level did not track push");

  assert_full_no_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full) else $error("full fifo lost an entry");
endmodule

// File: rtl/dacfe_wavegen.sv
module dacfe_wavegen
  import dacfe_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          adv,
  input  logic [1:0]    wave_sel,
  input  logic [DW-1:0] min_val,
  input  logic [DW-1:0] max_val,
  input  logic [DW-1:0] step_val,
  output logic [DW-1:0] cur
);
  logic          dn;
  logic [DW:0]   sum, floor_lim;
  logic [DW-1:0] up_next, nxt;
  logic          nxt_dn;
  wave_e         wsel;

  assign wsel      = wave_e'(wave_sel);
  assign sum       = {1'b0, cur} + {1'b0, step_val};
  assign floor_lim = {1'b0, min_val} + {1'b0, step_val};
  assign up_next   = (sum >= {1'b0, max_val}) ? max_val : sum[DW-1:0];

  always_comb begin
    nxt    = cur;
    nxt_dn = 1'b0;
    case (wsel)
      WAVE_SAW: nxt = (cur >= max_val) ? min_val : up_next;
      WAVE_TRI: begin
        if (!dn) begin
          nxt    = up_next;
          nxt_dn = (sum >= {1'b0, max_val});
        end else if ({1'b0, cur} <= floor_lim) begin
          nxt    = min_val;
          nxt_dn = 1'b0;
        end else begin
          nxt    = cur - step_val;
          nxt_dn = 1'b1;
        end
      end
      WAVE_SQR: nxt = (cur == max_val) ? min_val : max_val;
      default:  nxt = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      dn  <= 1'b0;
    end else if (!active) begin
      cur <= min_val;
      dn  <= 1'b0;
    end else if (adv) begin
      cur <= nxt;
      dn  <= nxt_dn;
    end
  end

  assert_tri_turn_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $rose(dn) && $stable(max_val)) |-> (cur == max_val))
    else $error("triangle turned below upper bound");

  assert_hold_no_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !adv) |=> $stable(cur)) else $error("generator moved without update");
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int DW    = 12,
  parameter int BW    = 16,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fmt_sel,
  input  logic          sync_en,
  input  logic          dma_en,
  input  logic          auto_en,
  input  logic          pdn,
  input  logic [1:0]    wave_sel,
  input  logic [DW-1:0] min_val,
  input  logic [DW-1:0] max_val,
  input  logic [DW-1:0] step_val,
  input  logic [LW-1:0] watermark,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [BW-1:0] wr_data,
  input  logic          dma_valid,
  output logic          dma_ready,
  input  logic [BW-1:0] dma_data,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic          sync_in,
  output logic [DW-1:0] dac_code,
  output logic          underflow
);
  logic          wr_fire, dma_fire, evt, live, pop;
  logic [DW-1:0] wr_code, dma_code, buf_q, code_q, head, gen_cur;
  logic [LW-1:0] level;
  logic          full, empty, uf_q, req_q;

  assign wr_ready  = !dma_en;
  assign wr_fire   = wr_valid && wr_ready;
  assign dma_ready = dma_en && !full;
  assign dma_fire  = dma_valid && dma_ready;
  assign evt       = sync_en ? sync_in : 1'b1;
  assign live      = evt && !pdn;
  assign pop       = live && dma_en && !auto_en && !empty;

  dacfe_fmt #(.BW(BW), .DW(DW)) u_fmt_wr (.sel(fmt_sel), .word(wr_data), .code(wr_code));
  dacfe_fmt #(.BW(BW), .DW(DW)) u_fmt_dma (.sel(fmt_sel), .word(dma_data), .code(dma_code));

  dacfe_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(!dma_en),
    .push(dma_fire), .push_data(dma_code), .pop(pop),
    .head(head), .level(level), .full(full), .empty(empty)
  );

  dacfe_wavegen #(.DW(DW)) u_gen (
    .clk(clk), .rst_n(rst_n), .active(auto_en), .adv(live && auto_en),
    .wave_sel(wave_sel), .min_val(min_val), .max_val(max_val),
    .step_val(step_val), .cur(gen_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       buf_q <= '0;
    else if (wr_fire) buf_q <= wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (auto_en) begin
      if (live) code_q <= gen_cur;
    end else if (dma_en) begin
      if (pop) code_q <= head;
    end else if (sync_en) begin
      if (live) code_q <= buf_q;
    end else if (!pdn) begin
      code_q <= wr_fire ? wr_code : buf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (live && sync_en && dma_en && !auto_en && empty) uf_q <= 1'b1;
      req_q <= dma_en && (level <= watermark) && !dma_ack;
    end
  end

  assign dma_req   = req_q;
  assign underflow = uf_q;
  assign dac_code  = pdn ? '0 : code_q;

  assert_ack_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_req) else $error("request survived acknowledge");

  assert_sync_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !sync_in) |=> $stable(code_q)) else $error("code moved without sync");

  assert_pdn_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> $stable(code_q)) else $error("code moved in power-down");

  assert_uf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow) else $error("underflow flag cleared");

  assert_uf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && sync_in && dma_en && !auto_en && empty) |=> $stable(code_q))
    else $error("code changed on empty fifo");
endmodule

// File: tb/sim_dacfe_top.sv
module sim_dacfe_top;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fmt_sel = 0, sync_en = 0, dma_en = 0, auto_en = 0, pdn = 0;
  logic [1:0] wave_sel = 0;
  logic [11:0] min_val = 0, max_val = 0, step_val = 0;
  logic [4:0] watermark = 5'd6;
  logic wr_valid = 0, dma_valid = 0, dma_ack = 0, sync_in = 0;
  logic [15:0] wr_data = 0, dma_data = 0;
  logic wr_ready, dma_ready, dma_req, underflow;
  logic [11:0] dac_code;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cur; bit m_dn;

  always #(CLK_P/2) clk = ~clk;

  dacfe_top u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sync_en(sync_en), .dma_en(dma_en),
    .auto_en(auto_en), .pdn(pdn), .wave_sel(wave_sel), .min_val(min_val),
    .max_val(max_val), .step_val(step_val), .watermark(watermark),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data),
    .dma_req(dma_req), .dma_ack(dma_ack), .sync_in(sync_in),
    .dac_code(dac_code), .underflow(underflow)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sync();
    sync_in = 1; step(); sync_in = 0;
  endtask

  task automatic bus_write(input logic [15:0] d);
    wr_valid = 1; wr_data = d; step(); wr_valid = 0;
  endtask

  task automatic model_adv(input int w, input int mn, input int mx, input int st);
    case (w)
      0: if (m_cur >= mx) m_cur = mn; else m_cur = (m_cur + st >= mx) ? mx : m_cur + st;
      1: if (!m_dn) begin
           if (m_cur + st >= mx) begin m_cur = mx; m_dn = 1; end else m_cur = m_cur + st;
         end else begin
           if (m_cur <= mn + st) begin m_cur = mn; m_dn = 0; end else m_cur = m_cur - st;
         end
      default: m_cur = (m_cur == mx) ? mn : mx;
    endcase
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [4];
    vals[0] = 16'h0ABC; vals[1] = 16'hFFFF; vals[2] = 16'h1234; vals[3] = 16'h8001;
    repeat (3) step();
    rst_n = 1; step();
    // R12 reset state
    check("R12 code", dac_code, 0);
    check("R12 req", dma_req, 0);
    check("R12 underflow", underflow, 0);

    // R1 / R2: async writes in both formats
    for (int f = 0; f < 2; f++) begin
      fmt_sel = f[0];
      for (int i = 0; i < 4; i++) begin
        bus_write(vals[i]);
        check(f == 0 ? "R1 R2 fmt0" : "R1 R2 fmt1", dac_code,
              f == 0 ? int'(vals[i][11:0]) : int'(vals[i][15:4]));
      end
    end

    // R3: sync gating
    fmt_sel = 0; sync_en = 1;
    bus_write(16'h0123);
    step(); step();
    check("R3 held before sync", dac_code, 12'h800);
    pulse_sync();
    check("R3 after sync", dac_code, 12'h123);

    // R10: power-down
    pdn = 1; step();
    check("R10 output zero", dac_code, 0);
    bus_write(16'h0777);
    pulse_sync();
    check("R10 sync ignored", dac_code, 0);
    pdn = 0; step();
    check("R10 code restored", dac_code, 12'h123);
    pulse_sync();
    check("R3 buffered write", dac_code, 12'h777);

    // R4 / R5 / R6: generator sweeps
    min_val = 12'd2; max_val = 12'd14;
    for (int w = 0; w < 3; w++) begin
      for (int s = 1; s <= 5; s += 2) begin
        auto_en = 0; wave_sel = w[1:0]; step_val = s[11:0]; step();
        auto_en = 1; step();
        m_cur = 2; m_dn = 0;
        for (int e = 0; e < 20; e++) begin
          pulse_sync();
          check(w == 0 ? "R4 sawtooth" : (w == 1 ? "R5 triangle" : "R6 square"),
                dac_code, m_cur);
          model_adv(w, 2, 14, s);
        end
      end
    end
    auto_en = 0; step();

    // R7 / R8: FIFO fill, back-pressure, order
    dma_en = 1; watermark = 5'd6; step();
    check("R7 bus ready low", wr_ready, 0);
    check("R8 req when empty", dma_req, 1);
    for (int i = 0; i < 16; i++) begin
      dma_valid = 1; dma_data = 16'h0100 + 16'(i); step();
    end
    check("R7 ready low when full", dma_ready, 0);
    dma_data = 16'h0EEE; step();
    dma_valid = 0; step();
    check("R8 req low above watermark", dma_req, 0);
    for (int i = 0; i < 16; i++) begin
      pulse_sync();
      check("R7 fifo order", dac_code, 12'h100 + i);
    end
    step();
    check("R8 req back at low level", dma_req, 1);
    dma_ack = 1; step(); dma_ack = 0;
    check("R8 req drops on ack", dma_req, 0);
    step();
    check("R8 req returns", dma_req, 1);

    // R9: underflow
    check("R9 flag clear before", underflow, 0);
    pulse_sync();
    check("R9 code held", dac_code, 12'h10F);
    check("R9 flag set", underflow, 1);
    step(); step();
    check("R9 flag sticky", underflow, 1);
    dma_valid = 1; dma_data = 16'h0321; step(); dma_valid = 0;
    pulse_sync();
    check("R9 resume", dac_code, 12'h321);
    check("R9 flag still set", underflow, 1);

    // R11: 24-step ramp
    dma_en = 0; step(); dma_en = 1; step(); step();
    begin
      int idx = 0, syncs = 0;
      for (int c = 0; c < 400 && syncs < 24; c++) begin
        if (dma_req && idx < 24) begin
          dma_valid = 1; dma_ack = 1; dma_data = 16'((idx * 4095) / 23); idx++;
        end else begin
          dma_valid = 0; dma_ack = 0;
        end
        sync_in = (c % 4 == 3);
        step();
        if (sync_in) begin
          check("R11 ramp entry", dac_code, (syncs * 4095) / 23);
          syncs++;
        end
      end
      sync_in = 0; dma_valid = 0; dma_ack = 0;
      check("R11 sync count", syncs, 24);
      check("R11 full scale", dac_code, 12'hFFF);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule